// File: doc/BRIEF.md
# RMII Receive Carrier and Data Output Stage

This block is the last stage of a PHY receive path on the reduced media-independent interface side. Decoded nibbles are pushed into a small elastic queue, and the block sends them out as two-bit symbols on `rxd`, timed by a 50 MHz reference clock. It also drives the single `crs_dv` pin, which has to carry both carrier sense and data-valid. While carrier is present the pin is high. When carrier goes away but queued data remains, the pin alternates so that a MAC can recover the two meanings separately.

The line rate is chosen by `speed_100`. At 100 Mb/s a new symbol goes out on every reference cycle, and `crs_dv` inverts on every cycle while the queue drains. At 10 Mb/s each symbol is held for ten cycles, and `crs_dv` inverts once every ten cycles. A false-carrier indication keeps `crs_dv` high and replaces the data with a fixed non-data code. Queued nibbles stay in place and drain once the indication clears.

Top module: `rmii_rx_mux`

## Requirements
- R1: After reset, `crs_dv` is 0, `rxd` is 2'b00 and `overflow` is 0, and the queue is empty.
- R2: While `carrier` or `false_carrier` is high, `crs_dv` is 1 from the next clock edge onward.
- R3: While carrier is present and the queue holds no data, `rxd` reads 2'b00.
- R4: Each nibble goes out as two symbols: bits [1:0] first, then bits [3:2].
- R5: With `speed_100`=1, a new symbol is presented on every reference cycle.
- R6: With `speed_100`=0, each symbol stays on `rxd` for 10 consecutive cycles.
- R7: With `speed_100`=1, carrier off and data still pending (queued, or the last symbol still shown), `crs_dv` inverts on every cycle.
- R8: With `speed_100`=0, carrier off and data still pending, `crs_dv` inverts once every 10 cycles.
- R9: Once carrier is off and no data is pending, `crs_dv` returns to 0 and stays there.
- R10: While `false_carrier` is high, `rxd` carries the code 2'b10 and no queued nibble is consumed. Those nibbles come out in order after the indication ends.
- R11: The queue holds 8 nibbles. A write that arrives while it is full is dropped, and `overflow` pulses high for one cycle on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Push `wr_nibble` into the queue |
| wr_nibble | input | 4 | Decoded receive nibble |
| carrier | input | 1 | Carrier sensed on the line |
| false_carrier | input | 1 | Carrier activity that did not decode as a frame |
| speed_100 | input | 1 | 1 selects 100 Mb/s, 0 selects 10 Mb/s |
| crs_dv | output | 1 | Combined carrier sense and data valid |
| rxd | output | 2 | Receive symbol |
| overflow | output | 1 | One-cycle pulse on a write dropped while full |

## Verification
The hardest situation to reach is the tail of a frame at 10 Mb/s, where carrier has already dropped and the alternation on `crs_dv` has to line up with symbols that are each held for ten cycles. It has to end exactly when the last symbol leaves `rxd`. The stimulus reaches this by raising carrier and pushing a burst of one to eight nibbles back to back at each speed, then dropping carrier straight after the final write. That leaves the queue as full as it can be when the drain starts. A bench model of the queue follows every cycle of the drain. Separate runs hold false carrier over queued data and write past the full mark.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;
  typedef logic [1:0] dibit_t;
  localparam dibit_t SYM_IDLE  = 2'b00;
  localparam dibit_t SYM_FALSE = 2'b10;
endpackage

// File: rtl/rmii_rx_fifo.sv
module rmii_rx_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             push_req,
  input  logic             pop,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             ovf
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [CNT_W-1:0] cnt_n;
  logic             ovf_n, push;

  assign full = (count == CNT_W'(DEPTH));
  assign push = push_req & ~full;
  assign head = mem[rd_q];

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    cnt_n = count + CNT_W'(push) - CNT_W'(pop);
    ovf_n = push_req & full;
    if (push) wr_n = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (pop)  rd_n = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      count <= cnt_n;
      ovf   <= ovf_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    (push_req && full) |=> ovf);
  p_count_bound_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    count <= CNT_W'(DEPTH));
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    pop |-> (count != '0));
endmodule

// File: rtl/rmii_rx_pacer.sv
module rmii_rx_pacer #(
  parameter int SLOW_DIV = 10,
  localparam int PW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic active,
  input  logic fast,
  output logic tick
);
  logic [PW-1:0] pace_q, pace_n;

  assign tick = fast | (pace_q == PW'(SLOW_DIV - 1));

  always_comb begin
    pace_n = pace_q + 1'b1;
    if (!active || tick) pace_n = '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) pace_q <= '0;
    else         pace_q <= pace_n;
  end

  generate
    if (SLOW_DIV > 1) begin : g_slow_chk
      p_slow_spacing_r6: assert property (@(posedge clk) disable iff (!rst_ni)
        (!fast && tick) |=> (fast || !tick));
    end
  endgenerate
endmodule

// File: rtl/rmii_rx_crs.sv
module rmii_rx_crs (
  input  logic clk,
  input  logic rst_ni,
  input  logic carrier_act,
  input  logic pending_n,
  input  logic tick,
  output logic crs_dv
);
  logic crs_n;

  always_comb begin
    if (carrier_act)    crs_n = 1'b1;
    else if (pending_n) crs_n = tick ? ~crs_dv : crs_dv;
    else                crs_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) crs_dv <= 1'b0;
    else         crs_dv <= crs_n;
  end

  p_carrier_high_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    carrier_act |=> crs_dv);
  p_drained_low_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (!carrier_act && !pending_n) |=> !crs_dv);
endmodule

// File: rtl/rmii_rx_mux.sv
module rmii_rx_mux #(
  parameter int DEPTH    = 8,
  parameter int SLOW_DIV = 10,
  localparam int NIB_W   = 4,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [NIB_W-1:0] wr_nibble,
  input  logic             carrier,
  input  logic             false_carrier,
  input  logic             speed_100,
  output logic             crs_dv,
  output logic [1:0]       rxd,
  output logic             overflow
);
  import rmii_rx_pkg::*;

  logic [1:0]       rst_sync;
  logic             rst_ni;
  logic [NIB_W-1:0] head;
  logic [CNT_W-1:0] count, count_after;
  logic             full, pop, tick, carrier_act, pending, pending_n, active;
  logic             phase_q, phase_n, shown_q, shown_n;
  dibit_t           rxd_q, rxd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  assign carrier_act = carrier | false_carrier;
  assign pending     = (count != '0) | shown_q;
  assign active      = carrier_act | pending;

  rmii_rx_fifo #(.DEPTH(DEPTH), .W(NIB_W)) u_fifo (
    .clk(clk), .rst_ni(rst_ni), .push_req(wr_en), .pop(pop), .din(wr_nibble),
    .head(head), .count(count), .full(full), .ovf(overflow)
  );

  rmii_rx_pacer #(.SLOW_DIV(SLOW_DIV)) u_pacer (
    .clk(clk), .rst_ni(rst_ni), .active(active), .fast(speed_100), .tick(tick)
  );

  always_comb begin
    rxd_n   = rxd_q;
    phase_n = phase_q;
    shown_n = shown_q;
    pop     = 1'b0;
    if (tick) begin
      if (false_carrier) begin
        rxd_n   = SYM_FALSE;
        shown_n = 1'b0;
      end else if (count != '0) begin
        rxd_n   = phase_q ? head[3:2] : head[1:0];
        pop     = phase_q;
        phase_n = ~phase_q;
        shown_n = 1'b1;
      end else begin
        rxd_n   = SYM_IDLE;
        shown_n = 1'b0;
      end
    end
    count_after = count + CNT_W'(wr_en & ~full) - CNT_W'(pop);
    pending_n   = (count_after != '0) | shown_n;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rxd_q   <= SYM_IDLE;
      phase_q <= 1'b0;
      shown_q <= 1'b0;
    end else begin
      rxd_q   <= rxd_n;
      phase_q <= phase_n;
      shown_q <= shown_n;
    end
  end

  assign rxd = rxd_q;

  rmii_rx_crs u_crs (
    .clk(clk), .rst_ni(rst_ni), .carrier_act(carrier_act),
    .pending_n(pending_n), .tick(tick), .crs_dv(crs_dv)
  );

  p_false_code_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (false_carrier && tick) |=> (rxd == SYM_FALSE));
  p_hold_between_ticks_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    !tick |=> $stable(rxd));
  p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (carrier && !false_carrier && count == '0 && tick) |=> (rxd == SYM_IDLE));
endmodule

// File: tb/rmii_rx_mux_test.sv
module rmii_rx_mux_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_nibble = 4'h0;
  logic       carrier = 1'b0, false_carrier = 1'b0, speed_100 = 1'b1;
  logic       crs_dv, overflow;
  logic [1:0] rxd;

  int checks = 0, errors = 0, ovf_seen = 0;
  bit m_hold = 1'b1;
  int q[$];
  int m_pace = 0, hd;
  bit m_phase = 0, m_out = 0, m_crs = 0, m_ovf = 0, m_act, m_tick, m_full;
  logic [1:0] m_rxd = 2'b00;

  rmii_rx_mux uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_nibble(wr_nibble),
    .carrier(carrier), .false_carrier(false_carrier), .speed_100(speed_100),
    .crs_dv(crs_dv), .rxd(rxd), .overflow(overflow)
  );

  always #5 clk = ~clk;

  // Cycle model built from R2..R11
  always @(posedge clk) begin
    if (!m_hold) begin
      m_act  = carrier || false_carrier || (q.size() != 0) || m_out;
      m_tick = speed_100 || (m_pace == 9);
      m_full = (q.size() == 8);
      m_ovf  = wr_en && m_full;
      if (m_tick) begin
        if (false_carrier) begin
          m_rxd = 2'b10; m_out = 0;
        end else if (q.size() != 0) begin
          hd = q[0];
          m_rxd = m_phase ? 2'((hd >> 2) & 3) : 2'(hd & 3);
          if (m_phase) hd = q.pop_front();
          m_phase = !m_phase; m_out = 1;
        end else begin
          m_rxd = 2'b00; m_out = 0;
        end
      end
      if (wr_en && !m_full) q.push_back(int'(wr_nibble));
      m_pace = (!m_act || m_tick) ? 0 : m_pace + 1;
      if (carrier || false_carrier) m_crs = 1;
      else if (q.size() != 0 || m_out) m_crs = m_tick ? !m_crs : m_crs;
      else m_crs = 0;
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #2;
    if (overflow) ovf_seen++;
    chk(int'(crs_dv), int'(m_crs), "R2 R7 R8 R9 crs_dv");
    chk(int'(rxd), int'(m_rxd), "R3 R4 R5 R6 R10 rxd");
    chk(int'(overflow), int'(m_ovf), "R11 overflow");
  endtask

  task automatic drain();
    for (int g = 0; g < 1000 && (q.size() != 0 || m_out || m_crs); g++) cyc();
    repeat (3) cyc();
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    chk(int'(crs_dv), 0, "R1 crs_dv");
    chk(int'(rxd), 0, "R1 rxd");
    chk(int'(overflow), 0, "R1 overflow");
    m_hold = 1'b0;

    // Sweep: both speeds, burst length 1..8, carrier dropped after last write
    for (int s = 0; s < 2; s++) begin
      for (int k = 1; k <= 8; k++) begin
        speed_100 = (s == 1);
        carrier = 1'b1;
        repeat (3) cyc();
        for (int n = 0; n < k; n++) begin
          wr_en = 1'b1;
          wr_nibble = 4'((n * 7 + k * 3 + s) & 15);
          cyc();
        end
        wr_en = 1'b0;
        carrier = 1'b0;
        drain();
      end
    end

    // R10: false carrier over queued data, both speeds
    for (int s = 0; s < 2; s++) begin
      speed_100 = (s == 1);
      carrier = 1'b1; false_carrier = 1'b1;
      for (int n = 0; n < 2; n++) begin
        wr_en = 1'b1; wr_nibble = 4'(9 + n * 4 + s); cyc();
      end
      wr_en = 1'b0;
      repeat (25) cyc();
      chk(int'(rxd), 2, "R10 false code");
      chk(int'(crs_dv), 1, "R10 crs_dv held");
      false_carrier = 1'b0; carrier = 1'b0;
      drain();
    end

    // R11: 10 back-to-back writes at 10 Mb/s, two must be dropped
    speed_100 = 1'b0;
    carrier = 1'b1;
    ovf_seen = 0;
    for (int n = 0; n < 10; n++) begin
      wr_en = 1'b1; wr_nibble = 4'(15 - n); cyc();
    end
    wr_en = 1'b0;
    carrier = 1'b0;
    drain();
    chk(ovf_seen, 2, "R11 dropped writes");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule